// File: doc/BRIEF.md
# Fractional Clock-Enable Multiplier with Committed Ratio Update

This block sits in the clock domain it controls and produces a clock-enable pulse stream. Each pulse lets one cycle of the input clock through. Time is cut into frames of 32 input cycles. In each frame, exactly `mult` of the 32 cycles raise an internal fractional enable, and these are spread as evenly as possible by a phase accumulator. A fixed integer post-divider (`POST_DIV`, chosen per instance) then keeps every `POST_DIV`-th fractional enable. The long-run output rate is therefore input rate × mult / 32 / POST_DIV.

Software programs the ratio through a small register port with two addresses, a control register and a kick register. The 5-bit ratio field lives in the control register at bit offset `FIELD_LSB`, and the multiplier it selects is 32 minus the field value. Writing the field alone changes nothing. The change is committed by writing a 1 to bit 31 of the kick register. That bit stays readable as 1 until the next frame boundary, where the new ratio becomes active and the bit clears itself. While a commit is pending, writes to the control register and new kick writes are refused, and a one-cycle `busy_err` pulse reports each refusal. Control and status pins are plain level or pulse signals; no data stream passes through the block, so it has no valid/ready handshake.

Top module: `frac_clk_mult`

## Requirements
- R1: After reset, the control register reads 0, the kick register reads 0, `busy_err` and `clk_en_out` are 0, and the active multiplier is 32.
- R2: The ratio field occupies control bits [FIELD_LSB+4:FIELD_LSB]. The active multiplier is 32 minus the field value, in the range 1..32, where field value 0 gives 32.
- R3: Frame cycles are numbered k = 0..31 from reset. In cycle k the fractional enable is raised if and only if floor((k+1)·m/32) > floor(k·m/32), where m is the active multiplier. Each frame therefore holds exactly m enables.
- R4: `clk_en_out` is high in the cycle after every POST_DIV-th fractional enable. The post-divider counts enables continuously across frames and is not reset at frame boundaries.
- R5: A write to the kick register (`reg_sel`=1) with bit 31 = 1 while no commit is pending sets the pending bit. The kick register reads as 32'h8000_0000 while a commit is pending and as 0 otherwise.
- R6: A pending commit loads the field into the active multiplier only on the clock edge that ends frame cycle 31. The pending bit clears on that same edge.
- R7: While a commit is pending, a control write, or a kick write with bit 31 = 1, is dropped and leaves the register contents unchanged. `busy_err` is high for the one cycle after each refused write.
- R8: All 32 control bits read back exactly as last accepted, so bits outside the field are preserved. A kick write with bit 31 = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be thinned |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 kick |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register named by reg_sel (combinational) |
| busy_err | output | 1 | One-cycle pulse after a write refused because a commit is pending |
| clk_en_out | output | 1 | Registered clock-enable output |

## Verification
The pattern generator is exercised with multipliers 32, 16, 27 and 1. Each is compared cycle by cycle against a reference built from the floor formula and a running post-divider count. The full rate 32 shows that no cycle is dropped. A rate of 16 checks an even split. A rate of 27 checks uneven spacing across the frame. A rate of 1 checks the single-enable edge case and the wrap of the post-divider across frames.

The commit path is tried four ways: a plain kick, a kick followed by refused control and kick writes, a kick write with bit 31 clear, and a kick issued close to a frame boundary. Between them these separate a correct handshake from early loading, from refusals that leak through, and from a pending bit that never clears.

// File: rtl/frac_mult_pkg.sv
package frac_mult_pkg;
  localparam int unsigned FRAME_LEN = 32;
  localparam int unsigned RATIO_W   = 5;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);
  localparam int unsigned MULT_W    = POS_W + 1;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned KICK_BIT  = 31;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_KICK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/frac_mult_regs.sv
module frac_mult_regs
  import frac_mult_pkg::*;
#(
  parameter int unsigned FIELD_LSB = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 sel,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  input  logic                 frame_end,
  output logic [RATIO_W-1:0]   field,
  output logic                 pending,
  output logic                 busy_err
);
  reg_sel_e         sel_e;
  logic [REG_W-1:0] ctrl_q;
  logic             kick_q;
  logic             busy_q;
  logic             ctrl_wr;
  logic             kick_wr;
  logic             refuse;

  assign sel_e   = reg_sel_e'(sel);
  assign ctrl_wr = wr_en && (sel_e == SEL_CTRL);
  assign kick_wr = wr_en && (sel_e == SEL_KICK) && wdata[KICK_BIT];
  assign refuse  = kick_q && (ctrl_wr || kick_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      kick_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= refuse;
      if (ctrl_wr && !kick_q)
        ctrl_q <= wdata;
      if (kick_q && frame_end)
        kick_q <= 1'b0;
      else if (kick_wr && !kick_q)
        kick_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_e == SEL_CTRL) rdata = ctrl_q;
    else                   rdata[KICK_BIT] = kick_q;
  end

  assign field    = ctrl_q[FIELD_LSB +: RATIO_W];
  assign pending  = kick_q;
  assign busy_err = busy_q;

  AST_KICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q && !frame_end) |=> kick_q) else $error("kick dropped early"); // R6
  AST_KICK_CLEARS_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q && frame_end) |=> !kick_q) else $error("kick not cleared"); // R6
  AST_REFUSED_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && kick_q) |=> $stable(ctrl_q)) else $error("ctrl changed while busy"); // R7
  AST_BUSY_AFTER_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_e == SEL_CTRL && kick_q) |=> busy_err) else $error("no busy pulse"); // R7
endmodule

// File: rtl/frac_mult_pattern.sv
module frac_mult_pattern
  import frac_mult_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic [RATIO_W-1:0] new_field,
  output logic               frame_end,
  output logic               frac_en
);
  localparam logic [MULT_W-1:0] FULL = MULT_W'(FRAME_LEN);

  logic [POS_W-1:0]  pos_q;
  logic [MULT_W-1:0] acc_q;
  logic [MULT_W-1:0] mult_q;
  logic [MULT_W:0]   sum;
  logic [MULT_W:0]   wrapped;
  logic              hit;

  assign sum       = {1'b0, acc_q} + {1'b0, mult_q};
  assign hit       = sum >= {1'b0, FULL};
  assign wrapped   = hit ? (sum - {1'b0, FULL}) : sum;
  assign frame_end = (pos_q == POS_W'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      acc_q  <= '0;
      mult_q <= FULL;
    end else begin
      pos_q <= pos_q + 1'b1;
      if (frame_end) begin
        acc_q <= '0;
        if (load_req)
          mult_q <= FULL - {1'b0, new_field};
      end else begin
        acc_q <= wrapped[MULT_W-1:0];
      end
    end
  end

  assign frac_en = hit;

  AST_MULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_q >= 1) && (mult_q <= FULL)) else $error("multiplier out of range"); // R2
  AST_MULT_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end && load_req) |=> $stable(mult_q)) else $error("mid-frame load"); // R6
  AST_ACC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < FULL) else $error("accumulator overflow"); // R3
endmodule

// File: rtl/frac_mult_postdiv.sv
module frac_mult_postdiv #(
  parameter int unsigned POST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frac_en,
  output logic en_out
);
  localparam int unsigned CNT_W = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POST_DIV - 1);

  logic out_q;

  generate
    if (POST_DIV == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= frac_en;
      end
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          out_q <= 1'b0;
        end else begin
          out_q <= frac_en && (cnt_q == LAST);
          if (frac_en)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  assign en_out = out_q;

  AST_OUT_NEEDS_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    en_out |-> $past(frac_en)) else $error("output without fractional enable"); // R4
endmodule

// File: rtl/frac_clk_mult.sv
module frac_clk_mult
  import frac_mult_pkg::*;
#(
  parameter int unsigned FIELD_LSB = 8,
  parameter int unsigned POST_DIV  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        busy_err,
  output logic        clk_en_out
);
  logic [RATIO_W-1:0] field;
  logic               pending;
  logic               frame_end;
  logic               frac_en;

  frac_mult_regs #(.FIELD_LSB(FIELD_LSB)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .frame_end (frame_end),
    .field     (field),
    .pending   (pending),
    .busy_err  (busy_err)
  );

  frac_mult_pattern u_pattern (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (pending),
    .new_field (field),
    .frame_end (frame_end),
    .frac_en   (frac_en)
  );

  frac_mult_postdiv #(.POST_DIV(POST_DIV)) u_postdiv (
    .clk     (clk),
    .rst_n   (rst_n),
    .frac_en (frac_en),
    .en_out  (clk_en_out)
  );

  AST_FIELD_FITS: assert property (@(posedge clk) FIELD_LSB + RATIO_W <= REG_W)
    else $error("field offset too large"); // R2
endmodule

// File: tb/test_frac_clk_mult.sv
`timescale 1ns/1ps
module test_frac_clk_mult;
  localparam int FLSB = 8;
  localparam int PDIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy_err;
  logic        clk_en_out;

  frac_clk_mult #(.FIELD_LSB(FLSB), .POST_DIV(PDIV)) i_frac_clk_mult (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_err(busy_err),
    .clk_en_out(clk_en_out)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int          m_pos, m_mult, m_hits;
  bit          m_kick, m_busy, m_out;
  logic [31:0] m_ctrl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_mult = 32; m_hits = 0;
      m_kick = 0; m_busy = 0; m_out = 0; m_ctrl = '0;
    end else begin
      bit hit, old_kick;
      hit = (((m_pos + 1) * m_mult) / 32) > ((m_pos * m_mult) / 32);
      m_out = hit && ((m_hits % PDIV) == PDIV - 1);
      if (hit) m_hits++;
      old_kick = m_kick;
      m_busy = 0;
      if (reg_wr_en) begin
        if (reg_sel == 1'b0) begin
          if (old_kick) m_busy = 1; else m_ctrl = reg_wdata;
        end else if (reg_wdata[31]) begin
          if (old_kick) m_busy = 1; else m_kick = 1;
        end
      end
      if (m_pos == 31 && old_kick) begin
        m_mult = 32 - int'((m_ctrl >> FLSB) & 32'h1f);
        m_kick = 0;
      end
      m_pos = (m_pos + 1) % 32;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the pulse outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(clk_en_out === m_out, "R3/R4 clk_en_out", 32'(clk_en_out), 32'(m_out));
      check(busy_err === m_busy, "R7 busy_err", 32'(busy_err), 32'(m_busy));
    end
  end

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input bit sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_sel = sel;
    #1;
    check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  task automatic wait_commit(input string req);
    int n = 0;
    reg_sel = 1'b1;
    while (reg_rdata[31] === 1'b1 && n < 40) begin
      @(negedge clk); #1; n++;
    end
    check(n <= 33 && reg_rdata === 32'h0, req, 32'(n), 32'd33);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(clk_en_out === 1'b0 && busy_err === 1'b0, "R1 outputs after reset",
          {30'b0, busy_err, clk_en_out}, 32'h0);
    rd(1'b0, 32'h0, "R1 ctrl after reset");
    rd(1'b1, 32'h0, "R1 kick after reset");
    run(70);                                   // R3 full rate m=32

    // R2/R8 field 16 with other bits set, no effect before kick
    wr(1'b0, 32'hA5A5_B0A5);
    rd(1'b0, 32'hA5A5_B0A5, "R8 ctrl readback");
    run(40);                                   // still m=32 (R6)
    wr(1'b1, 32'h8000_0000);
    rd(1'b1, 32'h8000_0000, "R5 kick pending reads 1");
    wr(1'b0, 32'h0000_0000);                   // refused
    rd(1'b0, 32'hA5A5_B0A5, "R7 refused ctrl write kept");
    wr(1'b1, 32'h8000_0000);                   // refused re-kick
    wait_commit("R6 kick clears within a frame");
    rd(1'b0, 32'hA5A5_B0A5, "R8 ctrl after commit");
    run(100);                                  // R3 m=16

    // R8 kick with bit 31 clear has no effect
    wr(1'b1, 32'h7FFF_FFFF);
    rd(1'b1, 32'h0, "R8 kick bit31=0 ignored");
    run(40);

    // R2 field 31 -> m=1
    wr(1'b0, 32'h0000_1F00);
    wr(1'b1, 32'h8000_0000);
    wait_commit("R6 commit m=1");
    run(130);

    // R2 field 5 -> m=27
    wr(1'b0, 32'h0000_0500);
    wr(1'b1, 32'h8000_0000);
    wait_commit("R6 commit m=27");
    run(100);

    // back to field 0 -> m=32
    wr(1'b0, 32'h1234_0034);
    wr(1'b1, 32'h8000_0000);
    wait_commit("R6 commit m=32");
    rd(1'b0, 32'h1234_0034, "R8 ctrl other bits");
    run(70);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule